// File: doc/BRIEF.md
# Three-Level to Two-Level Space Vector Reducer

This block sits in front of a two-level space vector modulator. It turns a three-level inverter reference into a two-level one. The three-level vector plane can be covered by six small hexagons. Each has the size of a two-level hexagon and is centred on one vertex of the inner hexagon. The block takes a reference vector in signed fixed-point alpha/beta form and picks the small hexagon that contains it. It then subtracts that hexagon's centre vector. The difference is a reference that an ordinary two-level stage can handle for sector, dwell time and switching order.

Along with the reduced vector, the block reports the chosen hexagon index and a three-bit per-phase offset mask. A downstream generator adds this mask to its two-level switching states to rebuild the three-level states. A two-level 0 becomes the lower of the phase's two levels and a 1 becomes the upper one. The same reduction can be applied again to extend the method to more levels. All outputs are registered, with a fixed latency of one cycle.

Top module: `tl_vector_reducer`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block clears every output: out_valid to 0, out_hex to 0, out_alpha and out_beta to 0, and out_offset to 0.
- R2: A sample with in_valid high at a rising edge appears at the outputs at that edge, and out_valid goes high for exactly that one cycle. A cycle with in_valid low gives out_valid low at the next edge.
- R3: While in_valid is low, out_hex, out_alpha, out_beta and out_offset hold their last values, whatever in_alpha and in_beta do.
- R4: Outside the near-origin zone, out_hex is k (0 to 5) when the reference angle lies in [60k-30, 60k+30) degrees. Angles are measured from the positive alpha axis toward positive beta. A reference within about one LSB of a boundary line may go to either neighbour.
- R5: When both |in_alpha| and |in_beta| are below NEAR_TH (256 by default), out_hex is 0.
- R6: The centre of hexagon k is (VUNIT*cos(60k), VUNIT*sin(60k)), rounded to the nearest LSB, with VUNIT = 4096 by default. out_alpha and out_beta equal the input reference minus that centre.
- R7: For a reference inside the outer three-level hexagon (radius 2*VUNIT) and outside the near-origin zone, the reduced vector lies inside the two-level hexagon. That hexagon has radius VUNIT and vertices at 0, 60, ... 300 degrees.
- R8: out_offset has bit 0 for phase a, bit 1 for phase b and bit 2 for phase c. A 1 means the phase uses the upper pair of levels (O/P) and a 0 means the lower pair (N/O). The masks are: hexagon 0 gives 001, 1 gives 011, 2 gives 010, 3 gives 110, 4 gives 100, 5 gives 101.
- R9: The reduced components saturate at the signed W-bit limits rather than wrap. For full-scale corner inputs they equal the exact difference, with the correct sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Reference sample strobe |
| in_alpha | input | W | Reference alpha component, signed |
| in_beta | input | W | Reference beta component, signed |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_alpha | output | W | Reduced alpha component, signed |
| out_beta | output | W | Reduced beta component, signed |
| out_hex | output | 3 | Selected small hexagon, 0 to 5 |
| out_offset | output | 3 | Per-phase level offset mask, bit 0 is phase a |

## Verification
On every cycle, the assertions check:
- the one-cycle valid timing and the holding of outputs while idle;
- that the hexagon index stays in range;
- that each offset mask raises one or two phases;
- that near-origin samples map to hexagon 0.

Only the bench's scenarios can show the rest. These are the angle-to-hexagon mapping across a full turn, the exact centre subtraction, containment of the reduced vector in the two-level hexagon, the specific mask for each hexagon, and the exact results at full-scale corners.

// File: rtl/tl_vred_pkg.sv
// Package: shared types and the hexagon-to-phase-offset table for the
// three-level to two-level vector reducer.
// Assumes hexagon k is centred at angle 60*k degrees.
package tl_vred_pkg;

    typedef logic [2:0] hex_idx_t;
    typedef logic [2:0] phase_mask_t;

    localparam int NUM_HEX = 6;

    // Map a hexagon index to its per-phase upper-level mask (bit0 = a).
    function automatic phase_mask_t hex_to_mask(input hex_idx_t k);
        case (k)
            3'd0:    return 3'b001;
            3'd1:    return 3'b011;
            3'd2:    return 3'b010;
            3'd3:    return 3'b110;
            3'd4:    return 3'b100;
            3'd5:    return 3'b101;
            default: return 3'b001;
        endcase
    endfunction

endpackage

// File: rtl/tl_vred_hex_select.sv
// Selects the small hexagon holding a reference vector.
// It picks the centre direction with the largest dot product, which is the
// nearest 60-degree wedge, and the lowest index wins a tie.
// Both components below NEAR_TH in magnitude force hexagon 0.
// Purely combinational.
module tl_vred_hex_select
    import tl_vred_pkg::*;
#(
    parameter int W       = 16,
    parameter int NEAR_TH = 256
) (
    input  logic signed [W-1:0] ref_a,
    input  logic signed [W-1:0] ref_b,
    output hex_idx_t            hex_idx
);
    localparam int DW = W + 3;
    localparam int PW = W + 18;
    localparam logic signed [PW-1:0] SQRT3_Q16 = PW'(113512);
    localparam logic signed [DW-1:0] TH        = DW'(NEAR_TH);

    logic signed [DW-1:0] a_e, b_s3, a_abs, b_abs;
    logic signed [PW-1:0] b_prod;
    logic signed [DW-1:0] dot [NUM_HEX];
    logic                 near_zero;
    hex_idx_t             best_i;

    // Extend alpha and scale beta by sqrt(3) in Q16.
    always_comb begin
        a_e    = DW'(ref_a);
        b_prod = PW'(ref_b) * SQRT3_Q16;
        b_s3   = DW'(b_prod >>> 16);
        a_abs  = (a_e < 0) ? -a_e : a_e;
        b_abs  = (DW'(ref_b) < 0) ? -DW'(ref_b) : DW'(ref_b);
    end

    // Twice the dot product of the reference with each centre direction.
    assign dot[0] = a_e <<< 1;
    assign dot[1] = a_e + b_s3;
    assign dot[2] = b_s3 - a_e;
    assign dot[3] = -(a_e <<< 1);
    assign dot[4] = -a_e - b_s3;
    assign dot[5] = a_e - b_s3;

    // Arg-max over the six directions, lowest index winning ties.
    always_comb begin
        logic signed [DW-1:0] best_v;
        best_v = dot[0];
        best_i = 3'd0;
        for (int i = 1; i < NUM_HEX; i++) begin
            if (dot[i] > best_v) begin
                best_v = dot[i];
                best_i = 3'(i);
            end
        end
    end

    // Near-origin detection and the final index.
    always_comb begin
        near_zero = (a_abs < TH) && (b_abs < TH);
        hex_idx   = near_zero ? 3'd0 : best_i;
    end

endmodule

// File: rtl/tl_vred_centre_rom.sv
// Centre vector of each small hexagon: VUNIT at 60*k degrees,
// rounded to the nearest LSB. The constants come from VUNIT alone.
module tl_vred_centre_rom
    import tl_vred_pkg::*;
#(
    parameter int W     = 16,
    parameter int VUNIT = 4096
) (
    input  hex_idx_t            hex_idx,
    output logic signed [W-1:0] ctr_a,
    output logic signed [W-1:0] ctr_b
);
    localparam longint YC = (longint'(VUNIT) * 56756 + 32768) >>> 16;
    localparam logic signed [W-1:0] VF = W'(VUNIT);
    localparam logic signed [W-1:0] VH = W'((VUNIT + 1) / 2);
    localparam logic signed [W-1:0] VY = W'(YC);

    // Constant lookup of the centre for the selected hexagon.
    always_comb begin
        case (hex_idx)
            3'd0:    begin ctr_a =  VF; ctr_b = '0;  end
            3'd1:    begin ctr_a =  VH; ctr_b =  VY; end
            3'd2:    begin ctr_a = -VH; ctr_b =  VY; end
            3'd3:    begin ctr_a = -VF; ctr_b = '0;  end
            3'd4:    begin ctr_a = -VH; ctr_b = -VY; end
            3'd5:    begin ctr_a =  VH; ctr_b = -VY; end
            default: begin ctr_a =  VF; ctr_b = '0;  end
        endcase
    end

endmodule

// File: rtl/tl_vred_sat_sub.sv
// One lane of saturating signed subtraction, y = x - c.
// On overflow the result clamps to the signed W-bit limits.
module tl_vred_sat_sub #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] x,
    input  logic signed [W-1:0] c,
    output logic signed [W-1:0] y
);
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] diff;

    // Widen by one bit, subtract, and clamp on a sign mismatch.
    always_comb begin
        diff = {x[W-1], x} - {c[W-1], c};
        if (diff[W] != diff[W-1]) y = diff[W] ? MINV : MAXV;
        else                      y = diff[W-1:0];
    end

endmodule

// File: rtl/tl_vector_reducer.sv
// Top level: reduces a three-level alpha/beta reference to a two-level one.
// It selects the small hexagon, subtracts that hexagon's centre with
// saturation, and looks up the per-phase offset mask.
// Outputs are registered with one cycle of latency and hold while idle.
// Reset is synchronous and active low.
module tl_vector_reducer
    import tl_vred_pkg::*;
#(
    parameter int W       = 16,
    parameter int VUNIT   = 4096,
    parameter int NEAR_TH = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_alpha,
    input  logic signed [W-1:0] in_beta,
    output logic                out_valid,
    output logic signed [W-1:0] out_alpha,
    output logic signed [W-1:0] out_beta,
    output logic [2:0]          out_hex,
    output logic [2:0]          out_offset
);
    localparam int NLANE = 2;

    hex_idx_t            sel_idx;
    logic signed [W-1:0] ctr_a, ctr_b;
    logic signed [W-1:0] lane_x [NLANE];
    logic signed [W-1:0] lane_c [NLANE];
    logic signed [W-1:0] lane_y [NLANE];

    tl_vred_hex_select #(.W(W), .NEAR_TH(NEAR_TH)) u_sel (
        .ref_a   (in_alpha),
        .ref_b   (in_beta),
        .hex_idx (sel_idx)
    );

    tl_vred_centre_rom #(.W(W), .VUNIT(VUNIT)) u_rom (
        .hex_idx (sel_idx),
        .ctr_a   (ctr_a),
        .ctr_b   (ctr_b)
    );

    assign lane_x[0] = in_alpha;
    assign lane_x[1] = in_beta;
    assign lane_c[0] = ctr_a;
    assign lane_c[1] = ctr_b;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        tl_vred_sat_sub #(.W(W)) u_sub (
            .x (lane_x[g]),
            .c (lane_c[g]),
            .y (lane_y[g])
        );
    end

    // Output registers: capture on in_valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_alpha  <= '0;
            out_beta   <= '0;
            out_hex    <= '0;
            out_offset <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_alpha  <= lane_y[0];
                out_beta   <= lane_y[1];
                out_hex    <= sel_idx;
                out_offset <= hex_to_mask(sel_idx);
            end
        end
    end

    // R2
    lat_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    lat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_hex) && $stable(out_alpha)
                       && $stable(out_beta) && $stable(out_offset)));

    // R4
    hex_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hex < 3'd6));

    // R8
    offset_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_offset) == 1 || $countones(out_offset) == 2));

    // R5
    near_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_alpha < NEAR_TH && in_alpha > -NEAR_TH
                  && in_beta < NEAR_TH && in_beta > -NEAR_TH) |=> (out_hex == 3'd0));

endmodule

// File: tb/tb_tl_vector_reducer.sv
module tb_tl_vector_reducer;
    localparam int    W     = 16;
    localparam int    VU    = 4096;
    localparam int    NTH   = 256;
    localparam real   PI    = 3.14159265358979;
    localparam real   SQ3   = 1.7320508075688772;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_alpha = '0;
    logic signed [W-1:0] in_beta = '0;
    logic                out_valid;
    logic signed [W-1:0] out_alpha, out_beta;
    logic [2:0]          out_hex, out_offset;

    int n_tests = 0;
    int n_fail  = 0;

    tl_vector_reducer #(.W(W), .VUNIT(VU), .NEAR_TH(NTH)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_alpha(in_alpha), .in_beta(in_beta),
        .out_valid(out_valid), .out_alpha(out_alpha), .out_beta(out_beta),
        .out_hex(out_hex), .out_offset(out_offset)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ctr_x(input int k);
        case (k)
            0: return VU;  1: return VU / 2;  2: return -VU / 2;
            3: return -VU; 4: return -VU / 2; default: return VU / 2;
        endcase
    endfunction

    function automatic int ctr_y(input int k);
        int c;
        c = $rtoi(VU * SQ3 / 2.0 + 0.5);
        case (k)
            0, 3:    return 0;
            1, 2:    return c;
            default: return -c;
        endcase
    endfunction

    function automatic int exp_mask(input int k);
        case (k)
            0: return 1; 1: return 3; 2: return 2;
            3: return 6; 4: return 4; default: return 5;
        endcase
    endfunction

    function automatic int exp_hex(input int a, input int b);
        real ang;
        int  k;
        if (a < NTH && a > -NTH && b < NTH && b > -NTH) return 0;
        ang = $atan2(real'(b), real'(a)) * 180.0 / PI;
        if (ang < -30.0) ang = ang + 360.0;
        k = $rtoi($floor((ang + 30.0) / 60.0));
        if (k >= 6) k = 0;
        return k;
    endfunction

    // Drive one sample on a falling edge; return one falling edge later.
    task automatic apply(input int a, input int b);
        @(negedge clk);
        in_valid = 1'b1;
        in_alpha = W'(a);
        in_beta  = W'(b);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Check index, offset and reduced vector of the sample just applied.
    task automatic check_sample(input int a, input int b, input bit inside_chk);
        int  k, ex, ey;
        real x, y;
        k  = exp_hex(a, b);
        ex = a - ctr_x(k);
        ey = b - ctr_y(k);
        chk(out_valid == 1'b1, "R2 out_valid", int'(out_valid), 1);
        chk(int'(out_hex) == k, "R4 hex index", int'(out_hex), k);
        chk(int'(out_offset) == exp_mask(k), "R8 offset mask", int'(out_offset), exp_mask(k));
        chk(int'(out_alpha) == ex, "R6 reduced alpha", int'(out_alpha), ex);
        chk(int'(out_beta) == ey, "R6 reduced beta", int'(out_beta), ey);
        if (inside_chk) begin
            x = real'(out_alpha);
            y = real'(out_beta);
            chk((y <= VU * SQ3 / 2.0 + 2.0) && (y >= -VU * SQ3 / 2.0 - 2.0),
                "R7 inside hexagon (beta)", int'(out_beta), 0);
            chk(SQ3 * ((x < 0) ? -x : x) + ((y < 0) ? -y : y) <= SQ3 * VU + 4.0,
                "R7 inside hexagon (slant)", int'(out_alpha), 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
        chk(out_hex == 3'd0, "R1 reset hex", int'(out_hex), 0);
        chk(out_alpha == '0 && out_beta == '0, "R1 reset vector", int'(out_alpha), 0);
        chk(out_offset == 3'd0, "R1 reset offset", int'(out_offset), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_sweep();
        real mags [3] = '{0.3, 1.0, 1.6};
        foreach (mags[m]) begin
            for (int i = 0; i < 24; i++) begin
                real th;
                int  a, b;
                th = (7.0 + 15.0 * i) * PI / 180.0;
                a  = $rtoi(mags[m] * VU * $cos(th));
                b  = $rtoi(mags[m] * VU * $sin(th));
                apply(a, b);
                check_sample(a, b, 1'b1);
            end
        end
    endtask

    task automatic t_near();
        apply(100, -50);
        check_sample(100, -50, 1'b0);
        chk(out_hex == 3'd0, "R5 near origin quad4", int'(out_hex), 0);
        apply(-200, 100);
        check_sample(-200, 100, 1'b0);
        chk(out_hex == 3'd0, "R5 near origin quad2", int'(out_hex), 0);
    endtask

    task automatic t_hold();
        logic [2:0]          h0;
        logic signed [W-1:0] a0, b0;
        apply(-3000, -2500);
        check_sample(-3000, -2500, 1'b1);
        h0 = out_hex; a0 = out_alpha; b0 = out_beta;
        in_alpha = W'(5000);
        in_beta  = W'(100);
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R2 valid drops", int'(out_valid), 0);
        chk(out_hex == h0, "R3 hex held", int'(out_hex), int'(h0));
        chk(out_alpha == a0 && out_beta == b0, "R3 vector held", int'(out_alpha), int'(a0));
    endtask

    task automatic t_fullscale();
        apply(32767, 32767);
        check_sample(32767, 32767, 1'b0);
        chk(out_alpha > 0 && out_beta > 0, "R9 no wrap positive", int'(out_alpha), 30719);
        apply(-32768, -32768);
        check_sample(-32768, -32768, 1'b0);
        chk(out_alpha < 0 && out_beta < 0, "R9 no wrap negative", int'(out_alpha), -30720);
        apply(32767, -32768);
        check_sample(32767, -32768, 1'b0);
    endtask

    task automatic t_reset_mid();
        apply(3000, 3000);
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_hex == 3'd0 && out_alpha == '0,
            "R1 reset mid-run", int'(out_hex), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_sweep();
                t_near();
                t_hold();
                t_fullscale();
                t_reset_mid();
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule